// File: doc/BRIEF.md
# Successive-Approximation Converter Serial Sequencer

This block is the digital heart of an eight-input successive-approximation converter, as seen from its four-wire serial port. A host lowers the select line, clocks in an 8-bit command on the data input, and then clocks out the conversion result on the data output. The block finds the command's start bit, decodes the input-mux selection and polarity, and drives the track/hold control. It raises a one-period strobe, then steps a 12-bit trial code into the capacitive DAC while it reads the comparator reply on each falling serial-clock edge. Each decided bit goes straight out on the data output.

All port inputs are sampled on a fast system clock, and the serial-clock edges are found by comparing consecutive samples. The outputs that would float on a pin are given here as a data bit plus an enable. The analog front end (mux, track/hold, DAC and comparator) lies outside the block. Only the externally clocked conversion mode is sequenced.

Top module: `sarseq_top`

## Requirements
- R1: While select is low, 0 bits sampled on `sdi` are ignored and leave the block waiting. The first 1 sampled after select falls is the start bit, which is control bit 1.
- R2: `sdi` is sampled on rising `sclk` edges. `sdo` changes only on falling `sclk` edges, so it is stable while `sclk` is high.
- R3: The control byte, first bit received to last, is: start, channel bits C2 C1 C0, polarity P (1 = unipolar, 0 = bipolar), input mode S (1 = single-ended, 0 = differential), and mode bits M1 M0. The mux outputs follow the rule `mux_pos` = C, `mux_neg` = {C2, C1, ~C0}, `mux_neg_com` = S and `bipolar` = ~P. Each field takes effect on the falling edge after its last bit arrives.
- R4: `track_en` rises on the falling edge after control bit 5 and falls on the falling edge after control bit 8.
- R5: When M1 M0 = 11, `strobe` is high from the falling edge after bit 8 to the next falling edge. With any other mode value there is no strobe and no conversion, and `sdo` stays 0.
- R6: At the strobe's start, `dac_trial` becomes 0x800. On each of the next 12 falling edges the current trial bit is kept if `cmp_hi` is 1 and cleared if it is 0, and the next lower bit is set. After the 12th decision, `dac_trial` holds the result.
- R7: The 16 bits the host samples on the rising edges after the control byte are a 0, then the 10 result bits MSB first, then 2 sub-LSB bits, then three 0s.
- R8: In bipolar mode the first decided bit on `sdo` is inverted, so the frame carries two's complement. In unipolar mode it is straight binary.
- R9: While `cs_n` is high, `sdo_en` and `strobe_en` are 0, and `sdo` and `strobe` are 0. One system clock after `cs_n` falls, both enables are 1 and `strobe` is 0.
- R10: Raising `cs_n` in the middle of a transaction aborts it. Track, strobe and conversion stop, and the next transaction searches for a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial command input |
| cmp_hi | input | 1 | Comparator reply: input at or above the DAC trial level |
| sdo | output | 1 | Serial result output |
| sdo_en | output | 1 | Drive enable for `sdo` |
| strobe | output | 1 | Conversion strobe |
| strobe_en | output | 1 | Drive enable for `strobe` |
| track_en | output | 1 | Track/hold: 1 = track, 0 = hold |
| mux_pos | output | 3 | Positive mux input |
| mux_neg | output | 3 | Negative mux input when differential |
| mux_neg_com | output | 1 | Negative input is the common pin |
| bipolar | output | 1 | Bipolar coding selected |
| dac_trial | output | 12 | Trial code for the capacitive DAC |

## Verification
A wrong bit counter or state shows up within one serial period. Track or strobe lands on the wrong falling edge, and the bench sees it in the edge-by-edge snapshots it takes before every rising edge. A fault in the trial register shows up as a wrong bit in the 16-bit frame starting on the first decision edge, and as a wrong final `dac_trial`, because the bench's comparator model follows the trial code. A missed abort leaves track or the strobe high, or spoils the frame of the next transaction. All of these are visible within a few system clocks of the select rising.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;
  localparam int CTL_BITS  = 8;   // command length, start bit included
  localparam int SEL_LAST  = 4;   // last channel bit position
  localparam int POL_AT    = 5;   // polarity bit position
  localparam int TRACK_AT  = 5;   // tracking starts after this bit
  localparam int MODE_AT   = 6;   // input-mode bit position
  localparam int CH_W      = 3;
  localparam int CNT_W     = $clog2(CTL_BITS + 1);
  localparam logic [1:0] MODE_EXT = 2'b11;

  typedef enum logic [1:0] {
    SQ_SEARCH = 2'd0,
    SQ_CTRL   = 2'd1,
    SQ_CONV   = 2'd2
  } sq_state_t;
endpackage

// File: rtl/sarseq_edge.sv
module sarseq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = !cs_n &&  sclk && !sclk_q;
  assign fall = !cs_n && !sclk &&  sclk_q;
endmodule

// File: rtl/sarseq_sar.sv
module sarseq_sar #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         abort,
  input  logic         cmp,
  input  logic         bipolar,
  output logic         dec_bit,
  output logic         last,
  output logic [W-1:0] trial
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] res_q, res_d, mask_q, mask_d;
  logic         upd;

  always_comb begin
    res_d  = res_q;
    mask_d = mask_q;
    if (abort) begin
      mask_d = '0;
    end else if (load) begin
      res_d  = '0;
      mask_d = TOP_BIT;
    end else if (step) begin
      if (cmp) res_d = res_q | mask_q;
      mask_d = mask_q >> 1;
    end
  end

  assign upd = abort | load | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      mask_q <= '0;
    end else if (upd) begin
      res_q  <= res_d;
      mask_q <= mask_d;
    end
  end

  assign dec_bit = cmp ^ (bipolar & mask_q[W-1]);
  assign last    = mask_q[0];
  assign trial   = res_q | mask_q;

  // R6: a decision step only happens while a trial bit is pending
  assert_step_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (mask_q != '0));
endmodule

// File: rtl/sarseq_ctrl.sv
module sarseq_ctrl
  import sarseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            rise,
  input  logic            fall,
  input  logic            sdi,
  input  logic            dec_bit,
  input  logic            sar_last,
  output logic            sar_load,
  output logic            sar_step,
  output logic            sar_abort,
  output logic            sdo,
  output logic            strobe,
  output logic            track,
  output logic [CH_W-1:0] mux_pos,
  output logic [CH_W-1:0] mux_neg,
  output logic            mux_neg_com,
  output logic            bipolar
);
  sq_state_t             st_q, st_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [CTL_BITS-1:0]   ctl_q, ctl_d;
  logic                  trk_q, trk_d, stb_q, stb_d, sdo_q, sdo_d;
  logic [CH_W-1:0]       pos_q, pos_d, neg_q, neg_d;
  logic                  com_q, com_d, bip_q, bip_d;

  always_comb begin
    st_d = st_q;   cnt_d = cnt_q; ctl_d = ctl_q;
    trk_d = trk_q; stb_d = stb_q; sdo_d = sdo_q;
    pos_d = pos_q; neg_d = neg_q; com_d = com_q; bip_d = bip_q;
    sar_load  = 1'b0;
    sar_step  = 1'b0;
    sar_abort = cs_n;
    if (cs_n) begin
      st_d  = SQ_SEARCH;
      cnt_d = '0;
      trk_d = 1'b0;
      stb_d = 1'b0;
      sdo_d = 1'b0;
    end else begin
      unique case (st_q)
        SQ_SEARCH: begin
          if (rise && sdi) begin
            st_d  = SQ_CTRL;
            cnt_d = CNT_W'(1);
            ctl_d = CTL_BITS'(1);
          end
          if (fall) sdo_d = 1'b0;
        end
        SQ_CTRL: begin
          if (rise) begin
            ctl_d = {ctl_q[CTL_BITS-2:0], sdi};
            cnt_d = cnt_q + CNT_W'(1);
          end
          if (fall) begin
            sdo_d = 1'b0;
            if (cnt_q == CNT_W'(SEL_LAST)) begin
              pos_d = ctl_q[CH_W-1:0];
              neg_d = {ctl_q[CH_W-1:1], ~ctl_q[0]};
            end
            if (cnt_q == CNT_W'(POL_AT))   bip_d = ~ctl_q[0];
            if (cnt_q == CNT_W'(TRACK_AT)) trk_d = 1'b1;
            if (cnt_q == CNT_W'(MODE_AT))  com_d = ctl_q[0];
            if (cnt_q == CNT_W'(CTL_BITS)) begin
              trk_d = 1'b0;
              if (ctl_q[1:0] == MODE_EXT) begin
                stb_d    = 1'b1;
                sar_load = 1'b1;
                st_d     = SQ_CONV;
              end else begin
                st_d = SQ_SEARCH;
              end
            end
          end
        end
        SQ_CONV: begin
          if (fall) begin
            stb_d    = 1'b0;
            sar_step = 1'b1;
            sdo_d    = dec_bit;
            if (sar_last) st_d = SQ_SEARCH;
          end
        end
        default: st_d = SQ_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_SEARCH;
      cnt_q <= '0;
      ctl_q <= '0;
      trk_q <= 1'b0;
      stb_q <= 1'b0;
      sdo_q <= 1'b0;
      pos_q <= '0;
      neg_q <= CH_W'(1);
      com_q <= 1'b1;
      bip_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ctl_q <= ctl_d;
      trk_q <= trk_d;
      stb_q <= stb_d;
      sdo_q <= sdo_d;
      pos_q <= pos_d;
      neg_q <= neg_d;
      com_q <= com_d;
      bip_q <= bip_d;
    end
  end

  assign sdo         = sdo_q;
  assign strobe      = stb_q;
  assign track       = trk_q;
  assign mux_pos     = pos_q;
  assign mux_neg     = neg_q;
  assign mux_neg_com = com_q;
  assign bipolar     = bip_q;

  // R1: a zero sampled while waiting never leaves the search state
  assert_zero_keeps_search_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_SEARCH && rise && !sdi && !cs_n) |=> (st_q == SQ_SEARCH));
  // R4: tracking is only possible while the command is being received
  assert_track_in_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trk_q |-> (st_q == SQ_CTRL));
  // R5: the strobe ends at the first falling edge it sees
  assert_strobe_one_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q && fall) |=> !stb_q);
  // R10: deselecting clears the transaction
  assert_abort_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (st_q == SQ_SEARCH && !trk_q && !stb_q));
endmodule

// File: rtl/sarseq_top.sv
module sarseq_top #(
  parameter int RES_BITS = 10,
  parameter int SUB_BITS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     sclk,
  input  logic                     sdi,
  input  logic                     cmp_hi,
  output logic                     sdo,
  output logic                     sdo_en,
  output logic                     strobe,
  output logic                     strobe_en,
  output logic                     track_en,
  output logic [2:0]               mux_pos,
  output logic [2:0]               mux_neg,
  output logic                     mux_neg_com,
  output logic                     bipolar,
  output logic [RES_BITS+SUB_BITS-1:0] dac_trial
);
  localparam int W = RES_BITS + SUB_BITS;

  logic [1:0] rs_q;
  logic       rst_i;
  logic       rise, fall, sar_load, sar_step, sar_abort, dec_bit, sar_last;
  logic       en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) en_q <= 1'b0;
    else        en_q <= ~cs_n;
  end
  assign sdo_en    = en_q;
  assign strobe_en = en_q;

  sarseq_edge u_edge (
    .clk(clk), .rst_n(rst_i), .sclk(sclk), .cs_n(cs_n),
    .rise(rise), .fall(fall)
  );

  sarseq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_i), .cs_n(cs_n), .rise(rise), .fall(fall),
    .sdi(sdi), .dec_bit(dec_bit), .sar_last(sar_last),
    .sar_load(sar_load), .sar_step(sar_step), .sar_abort(sar_abort),
    .sdo(sdo), .strobe(strobe), .track(track_en),
    .mux_pos(mux_pos), .mux_neg(mux_neg), .mux_neg_com(mux_neg_com),
    .bipolar(bipolar)
  );

  sarseq_sar #(.W(W)) u_sar (
    .clk(clk), .rst_n(rst_i), .load(sar_load), .step(sar_step),
    .abort(sar_abort), .cmp(cmp_hi), .bipolar(bipolar),
    .dec_bit(dec_bit), .last(sar_last), .trial(dac_trial)
  );

  // R9: nothing is driven high while the pins are released
  assert_quiet_when_released_R9: assert property (@(posedge clk) disable iff (!rst_i)
    !en_q |-> (!sdo && !strobe));
endmodule

// File: tb/sim_sarseq_top.sv
module sim_sarseq_top;
  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdi, cmp_hi;
  logic sdo, sdo_en, strobe, strobe_en, track_en, mux_neg_com, bipolar;
  logic [2:0] mux_pos, mux_neg;
  logic [11:0] dac_trial, vin;

  int checks = 0, failures = 0;
  bit done = 0;

  logic       so_s [1:24];
  logic       so_hi[1:24];
  logic       trk_s[1:24];
  logic       stb_s[1:24];
  logic [2:0] pos_s[1:24];
  logic       pre_bad;

  always #4 clk = ~clk;   // 125 MHz

  assign cmp_hi = (vin >= dac_trial);

  sarseq_top u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .cmp_hi(cmp_hi), .sdo(sdo), .sdo_en(sdo_en), .strobe(strobe),
    .strobe_en(strobe_en), .track_en(track_en), .mux_pos(mux_pos),
    .mux_neg(mux_neg), .mux_neg_com(mux_neg_com), .bipolar(bipolar),
    .dac_trial(dac_trial)
  );

  // {command, leading zeros, analog level}
  localparam logic [23:0] VEC [6] = '{
    {8'h8F, 4'd0, 12'hABC},
    {8'hD3, 4'd3, 12'h000},
    {8'hFB, 4'd5, 12'hFFF},
    {8'hA7, 4'd1, 12'h801},
    {8'hBF, 4'd2, 12'h7FE},
    {8'hE3, 4'd0, 12'h555}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic txn(input logic [7:0] ctl, input int npre, input int abort_at);
    pre_bad = 1'b0;
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < npre; i++) begin
      if (track_en || strobe) pre_bad = 1'b1;
      sdi = 1'b0; sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    for (int k = 1; k <= 24; k++) begin
      if (k == abort_at) begin
        cs_n = 1'b1;
        return;
      end
      so_s[k] = sdo; trk_s[k] = track_en; stb_s[k] = strobe; pos_s[k] = mux_pos;
      sdi = (k <= 8) ? ctl[8-k] : 1'b0;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      so_hi[k] = sdo;
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    sdi = 1'b0; cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [15:0] frame_got();
    logic [15:0] f;
    for (int k = 9; k <= 24; k++) f[24-k] = so_s[k];
    return f;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [2:0] prev_pos;
    logic [7:0] c;
    logic [15:0] exp_f;
    bit hi_ok, stb_none;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; vin = 12'h000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    chk("R9 reset sdo_en", sdo_en, 0);
    chk("R9 reset strobe_en", strobe_en, 0);
    chk("R4 reset track", track_en, 0);
    chk("R6 reset dac", dac_trial, 0);
    chk("R3 reset mux", {mux_pos, mux_neg, mux_neg_com, bipolar}, {3'd0, 3'd1, 1'b1, 1'b0});

    // R9: enables follow select
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 enable after select", {sdo_en, strobe_en, strobe}, 3'b110);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 release after deselect", {sdo_en, strobe_en}, 2'b00);

    // vector table
    prev_pos = 3'd0;
    foreach (VEC[i]) begin
      c   = VEC[i][23:16];
      vin = VEC[i][11:0];
      txn(c, int'(VEC[i][15:12]), 0);
      exp_f = {1'b0, vin ^ (c[3] ? 12'h000 : 12'h800), 3'b000};
      chk("R7 R8 frame", frame_got(), exp_f);
      chk("R6 final trial", dac_trial, vin);
      chk("R1 zeros before start", pre_bad, 0);
      chk("R4 track edges", {trk_s[5], trk_s[6], trk_s[8], trk_s[9]}, 4'b0110);
      chk("R5 strobe window", {stb_s[8], stb_s[9], stb_s[10]}, 3'b010);
      chk("R3 channel timing", {pos_s[4], pos_s[5]}, {prev_pos, c[6:4]});
      chk("R3 mux fields", {mux_pos, mux_neg, mux_neg_com, bipolar},
          {c[6:4], c[6:5], ~c[4], c[2], ~c[3]});
      hi_ok = 1'b1;
      for (int k = 10; k <= 21; k++) if (so_hi[k] !== so_s[k]) hi_ok = 1'b0;
      chk("R2 sdo stable while sclk high", hi_ok, 1);
      prev_pos = c[6:4];
    end

    // R5: non-external mode gives no strobe or conversion
    vin = 12'hFFF;
    txn(8'h9D, 1, 0);
    stb_none = 1'b1;
    for (int k = 1; k <= 24; k++) if (stb_s[k] !== 1'b0) stb_none = 1'b0;
    chk("R5 no strobe other mode", stb_none, 1);
    chk("R5 sdo zero other mode", frame_got(), 16'h0000);
    chk("R5 dac untouched other mode", dac_trial, 12'h555);
    chk("R4 track still pulses", trk_s[6], 1);

    // R10: abort while tracking
    vin = 12'h3C5;
    txn(8'h8F, 0, 7);
    repeat (3) @(negedge clk);
    chk("R10 abort clears track", track_en, 0);
    chk("R9 abort releases pins", {sdo_en, strobe_en}, 2'b00);
    txn(8'h8F, 2, 0);
    chk("R10 frame after abort", frame_got(), {1'b0, 12'h3C5, 3'b000});

    // R10: abort during conversion
    vin = 12'hFFF;
    txn(8'hBF, 0, 14);
    repeat (3) @(negedge clk);
    chk("R10 abort in conversion", {strobe, sdo, sdo_en}, 3'b000);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 strobe low after reselect", {strobe_en, strobe, sdo}, 3'b100);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    vin = 12'h0F0;
    txn(8'hBF, 0, 0);
    chk("R10 R6 conversion after abort", dac_trial, 12'h0F0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule